// File: doc/BRIEF.md
# Multi-Operand Prefix-Sum Unit

This block holds one shared base register and serves atomic fetch-and-add requests from a set of thread processors. On each port a processor presents a valid strobe and an increment. The unit adds the increment to the base and hands back the value the base held just before that increment. All requests that show up in the same clock cycle are merged into one multi-operand operation, which finishes in a single cycle. Within a cycle, ports are ordered by index, lowest first. Each requester therefore gets a distinct slot, and the base advances by the sum of all increments.

A master port can load the base with a new value and can read it at any time. A load takes precedence over requests that arrive in the same cycle. Those requests are kept inside the unit and served in the first cycle without a load. A typical use is stream compaction: every thread that owns a nonzero element adds 1 and writes its element to the slot index it gets back. The final base then equals the number of elements kept.

Top module: `mops_unit`

## Requirements
- R1: After reset the base reads 0 and no port shows an ack.
- R2: A lone request with increment I, presented while the base is B, gives an ack on that port in the next cycle with return value B. From that cycle the base reads B+I.
- R3: Requests in the same cycle are ordered by ascending port index. Port k returns the base plus the increments of all lower-indexed requesting ports, and every requester is acked in the same following cycle.
- R4: After a merged cycle the base equals its earlier value plus the sum of all increments served. When nothing is served and no load occurs, the base stays unchanged.
- R5: An ack lasts exactly one cycle. Ports that did not request show no ack.
- R6: Base and return values are 32 bits wide and wrap modulo 2^32.
- R7: A master load makes the base equal the loaded value in the next cycle. Requests in that same cycle change neither the base nor any ack in that next cycle.
- R8: Requests that coincide with a load are kept and served in the first cycle without a load, starting from the loaded value. They are acked one cycle later and the requester does not present them again.
- R9: Requests in consecutive cycles see the base as updated by the cycle before, so no update is lost.
- R10: A request with increment 0 gets the current running value and does not move the base. Ports that do not request are left out of the sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | PORTS | One request strobe per port |
| req_inc | input | PORTS*WIDTH | Increments; port i uses bits [i*WIDTH +: WIDTH] |
| ack | output | PORTS | One-cycle completion pulse per port |
| ret_val | output | PORTS*WIDTH | Value returned to each port, same slicing as req_inc |
| init_we | input | 1 | Master load strobe |
| init_val | input | WIDTH | Value loaded into the base |
| base_out | output | WIDTH | Current base value |

## Verification
The hardest situation to reach is a load that lands in the same cycle as a burst of requests. Both the hold path and the merge path must be exercised at once, starting from a base value that was only just loaded. The bench drives the load strobe and two request strobes together for one cycle and then releases all of them. It checks that the cycle after shows only the new base and no acks. It then checks that the following cycle acks the kept requests with slots counted from the loaded value. Wrap-around is reached by loading a base just below 2^32 and then merging increments across the boundary.

// File: rtl/mops_pkg.sv
package mops_pkg;
    localparam int unsigned PORTS_DEF = 4;
    localparam int unsigned WIDTH_DEF = 32;
endpackage

// File: rtl/mops_hold.sv
module mops_hold #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_v,
    input  logic [WIDTH-1:0] req_inc,
    input  logic             stall,
    output logic             eff_v,
    output logic [WIDTH-1:0] eff_inc
);
    typedef struct packed {
        logic             held;
        logic [WIDTH-1:0] inc;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        eff_v   = st_q.held | req_v;
        eff_inc = st_q.held ? st_q.inc : req_inc;
        st_d    = st_q;
        if (stall) begin
            st_d.held = eff_v;
            st_d.inc  = eff_inc;
        end else begin
            st_d.held = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8
    held_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && req_v) |=> (eff_v && eff_inc == $past(req_inc)));
endmodule

// File: rtl/mops_scan.sv
module mops_scan #(
    parameter int unsigned PORTS = 4,
    parameter int unsigned WIDTH = 32
) (
    input  logic [PORTS-1:0]       v,
    input  logic [PORTS*WIDTH-1:0] inc,
    input  logic [WIDTH-1:0]       base,
    output logic [PORTS*WIDTH-1:0] pre,
    output logic [WIDTH-1:0]       total
);
    logic [WIDTH-1:0] acc [PORTS+1];

    assign acc[0] = base;

    for (genvar i = 0; i < PORTS; i++) begin : g_chain
        assign pre[i*WIDTH +: WIDTH] = acc[i];
        assign acc[i+1] = acc[i] + (v[i] ? inc[i*WIDTH +: WIDTH] : '0);
    end

    assign total = acc[PORTS];
endmodule

// File: rtl/mops_unit.sv
module mops_unit
    import mops_pkg::*;
#(
    parameter int unsigned PORTS = PORTS_DEF,
    parameter int unsigned WIDTH = WIDTH_DEF
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [PORTS-1:0]       req_valid,
    input  logic [PORTS*WIDTH-1:0] req_inc,
    output logic [PORTS-1:0]       ack,
    output logic [PORTS*WIDTH-1:0] ret_val,
    input  logic                   init_we,
    input  logic [WIDTH-1:0]       init_val,
    output logic [WIDTH-1:0]       base_out
);
    localparam int unsigned VEC_W = PORTS * WIDTH;

    typedef struct packed {
        logic [WIDTH-1:0] base;
        logic [PORTS-1:0] ack;
        logic [VEC_W-1:0] ret;
    } unit_t;

    unit_t st_d, st_q;

    logic [PORTS-1:0] eff_v;
    logic [VEC_W-1:0] eff_inc;
    logic [VEC_W-1:0] pre;
    logic [WIDTH-1:0] total;

    for (genvar i = 0; i < PORTS; i++) begin : g_lane
        mops_hold #(.WIDTH(WIDTH)) u_hold (
            .clk     (clk),
            .rst_n   (rst_n),
            .req_v   (req_valid[i]),
            .req_inc (req_inc[i*WIDTH +: WIDTH]),
            .stall   (init_we),
            .eff_v   (eff_v[i]),
            .eff_inc (eff_inc[i*WIDTH +: WIDTH])
        );
    end

    mops_scan #(.PORTS(PORTS), .WIDTH(WIDTH)) u_scan (
        .v     (eff_v),
        .inc   (eff_inc),
        .base  (st_q.base),
        .pre   (pre),
        .total (total)
    );

    always_comb begin
        st_d = st_q;
        if (init_we) begin
            st_d.base = init_val;
            st_d.ack  = '0;
        end else begin
            st_d.base = total;
            st_d.ack  = eff_v;
            for (int i = 0; i < PORTS; i++) begin
                if (eff_v[i]) st_d.ret[i*WIDTH +: WIDTH] = pre[i*WIDTH +: WIDTH];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ack      = st_q.ack;
    assign ret_val  = st_q.ret;
    assign base_out = st_q.base;

    // R7
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_we |=> (base_out == $past(init_val) && ack == '0));

    // R3
    first_port_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack[0] |-> ret_val[WIDTH-1:0] == $past(base_out));

    // R4
    idle_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_we && req_valid == '0 && eff_v == '0) |=> $stable(base_out));

    // R5
    ack_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_we && eff_v == '0) |=> ack == '0);
endmodule

// File: tb/mops_unit_bench.sv
`timescale 1ns/1ps
module mops_unit_bench;
    localparam int N = 4;
    localparam int W = 32;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   req_valid = '0;
    logic [N*W-1:0] req_inc = '0;
    logic [N-1:0]   ack;
    logic [N*W-1:0] ret_val;
    logic           init_we = 1'b0;
    logic [W-1:0]   init_val = '0;
    logic [W-1:0]   base_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    mops_unit u_mops_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_inc(req_inc),
        .ack(ack), .ret_val(ret_val), .init_we(init_we), .init_val(init_val),
        .base_out(base_out)
    );

    function automatic logic [W-1:0] rv(int p);
        return ret_val[p*W +: W];
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic set_req(input int p, input logic [W-1:0] inc);
        req_valid[p] = 1'b1;
        req_inc[p*W +: W] = inc;
    endtask

    task automatic step_clear;
        @(negedge clk);
        req_valid = '0;
        req_inc   = '0;
        init_we   = 1'b0;
    endtask

    task automatic do_load(input logic [W-1:0] v);
        init_we = 1'b1; init_val = v;
        step_clear();
        chk(base_out == v, "R7 load value", base_out, v);
        chk(ack == '0, "R7 no ack after load", W'(ack), 0);
    endtask

    task automatic t_reset;
        chk(base_out == 0, "R1 base after reset", base_out, 0);
        chk(ack == '0, "R1 ack after reset", W'(ack), 0);
    endtask

    task automatic t_single;
        do_load(100);
        set_req(2, 7);
        step_clear();
        chk(ack == 4'b0100, "R2 single ack", W'(ack), 4);
        chk(rv(2) == 100, "R2 single ret", rv(2), 100);
        chk(base_out == 107, "R2 single base", base_out, 107);
    endtask

    task automatic t_all;
        set_req(0, 1); set_req(1, 2); set_req(2, 3); set_req(3, 4);
        step_clear();
        chk(ack == 4'b1111, "R3 all acked", W'(ack), 15);
        chk(rv(0) == 107, "R3 port0", rv(0), 107);
        chk(rv(1) == 108, "R3 port1", rv(1), 108);
        chk(rv(2) == 110, "R3 port2", rv(2), 110);
        chk(rv(3) == 113, "R3 port3", rv(3), 113);
        chk(base_out == 117, "R4 merged base", base_out, 117);
    endtask

    task automatic t_subset;
        set_req(0, 10); set_req(3, 20);
        step_clear();
        chk(ack == 4'b1001, "R5 subset ack", W'(ack), 9);
        chk(rv(3) == 127, "R3 subset port3", rv(3), 127);
        chk(base_out == 147, "R4 subset base", base_out, 147);
        @(negedge clk);
        chk(ack == '0, "R5 ack one cycle", W'(ack), 0);
        chk(base_out == 147, "R4 idle base", base_out, 147);
    endtask

    task automatic t_zero;
        set_req(1, 0); set_req(2, 5);
        step_clear();
        chk(rv(1) == 147, "R10 zero inc ret", rv(1), 147);
        chk(rv(2) == 147, "R10 after zero inc ret", rv(2), 147);
        chk(base_out == 152, "R10 zero inc base", base_out, 152);
    endtask

    task automatic t_wrap;
        do_load(32'hFFFF_FFFE);
        set_req(0, 1); set_req(1, 3);
        step_clear();
        chk(rv(1) == 32'hFFFF_FFFF, "R6 wrap ret", rv(1), 32'hFFFF_FFFF);
        chk(base_out == 2, "R6 wrap base", base_out, 2);
    endtask

    task automatic t_load_clash;
        init_we = 1'b1; init_val = 50;
        set_req(0, 4); set_req(2, 6);
        step_clear();
        chk(base_out == 50, "R7 clash base", base_out, 50);
        chk(ack == '0, "R7 clash no ack", W'(ack), 0);
        @(negedge clk);
        chk(ack == 4'b0101, "R8 held ack", W'(ack), 5);
        chk(rv(0) == 50, "R8 held port0", rv(0), 50);
        chk(rv(2) == 54, "R8 held port2", rv(2), 54);
        chk(base_out == 60, "R8 held base", base_out, 60);
        @(negedge clk);
        chk(ack == '0, "R8 held served once", W'(ack), 0);
    endtask

    task automatic t_b2b;
        set_req(0, 5);
        @(negedge clk);
        req_valid = '0; req_inc = '0;
        set_req(1, 9);
        chk(rv(0) == 60, "R9 first ret", rv(0), 60);
        step_clear();
        chk(rv(1) == 65, "R9 second ret", rv(1), 65);
        chk(base_out == 74, "R9 base", base_out, 74);
    endtask

    task automatic t_compact;
        logic [W-1:0] elems [N];
        elems[0] = 0; elems[1] = 7; elems[2] = 0; elems[3] = 3;
        do_load(0);
        for (int p = 0; p < N; p++) if (elems[p] != 0) set_req(p, 1);
        step_clear();
        chk(ack == 4'b1010, "R10 compaction ack", W'(ack), 10);
        chk(rv(1) == 0 && rv(3) == 1, "R10 compaction slots", rv(3), 1);
        chk(base_out == 2, "R4 compaction count", base_out, 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_all();
        t_subset();
        t_zero();
        t_wrap();
        t_load_clash();
        t_b2b();
        t_compact();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R1 actual=timeout expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule